// File: doc/BRIEF.md
# Command Stream Packet Header Parser

This block sits at the front of a command processor and receives a stream of 32-bit command words on a valid/ready input. Each header word is classified by its top nibble into one of five packet formats. The block pulls out the payload length and either a target register index or an opcode. It checks the parity bits that guard the fields of the two newer formats. The payload words that follow the header are passed straight through to a valid/ready output, each tagged with its destination. For register-write packets the destination register index advances by one on every word.

No-op headers are absorbed. Headers with an unknown type are dropped and raise a sticky error flag. Headers with a parity fault raise a different sticky flag, and their payload is swallowed without reaching the output. After the last payload word of any packet, the next input word is treated as a header.

Top module: `cmd_hdr_parser`

## Requirements
- R1: After a synchronous reset, in_ready is 1, out_valid is 0, and err_parity and err_type are both 0.
- R2: A header with bits [31:28] = 0x4 is a register-write packet. Its payload count is bits [6:0], its count parity is bit 7, its 18-bit register index is bits [25:8] and its index parity is bit 27. Each payload word leaves with out_kind = 0, and out_target starts at the index and rises by one per word, wrapping modulo 2^18. A count of 127, the largest the field holds, is carried in full.
- R3: A header with bits [31:28] = 0x0 is a register-write packet carrying (count − 1) in bits [27:16] and a 15-bit register index in bits [14:0]. It emits count words with out_kind = 0, and out_target rises by one per word from the index.
- R4: A header with bits [31:28] = 0xC is an opcode packet carrying (count − 1) in bits [27:16] and an 8-bit opcode in bits [15:8]. It emits count words with out_kind = 1, and out_target holds the opcode for every word.
- R5: A header with bits [31:28] = 0x7 is an opcode packet. Its count is bits [14:0], its count parity is bit 15, its 7-bit opcode is bits [22:16] and its opcode parity is bit 23. It emits count words with out_kind = 1 and out_target equal to the opcode.
- R6: A parity bit is correct when it is 1 exactly when its field holds an even number of ones. If either parity bit of a 0x4 or 0x7 header is wrong, err_parity is set. The number of words given by the header's count field is then consumed with no output, and the next word is parsed as a header.
- R7: A header with bits [31:28] = 0x8 is a one-word no-op. It produces no output, and the next word is a header.
- R8: A header whose top nibble is not 0x0, 0x4, 0x7, 0x8 or 0xC sets err_type and is dropped with no output. The next word is a header.
- R9: A 0x4 or 0x7 header with a count of zero produces no output, and the next word is a header.
- R10: out_last is 1 on the final payload word of a packet and 0 on every other word.
- R11: While payload is flowing, out_valid follows in_valid, out_data equals in_data, and in_ready equals out_ready, so a stalled word stays on the output until it is accepted.
- R12: err_parity and err_type stay set until reset, whatever traffic follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input command word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Input word accepted this cycle when high with in_valid |
| out_valid | output | 1 | Payload word valid |
| out_ready | input | 1 | Downstream accepts the payload word |
| out_data | output | 32 | Payload word |
| out_kind | output | 1 | 0 = register write, 1 = opcode payload |
| out_target | output | 18 | Register index or opcode for this word |
| out_last | output | 1 | Final word of the packet |
| err_parity | output | 1 | Sticky parity fault flag |
| err_type | output | 1 | Sticky unknown packet type flag |

## Verification
The assertions take for granted that reset is held at the first clock edge, so the parser state is known before any property is evaluated. They also assume that a payload word, once offered, is not withdrawn by the upstream before its handshake. The stimulus keeps within both: it asserts reset first, and its driver holds in_valid and in_data steady until in_ready is seen. Meanwhile a pseudo-random out_ready pattern stalls the output in the middle of packets, which exercises the stepping of the index and the holding of the opcode across stalls.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int WORD_W = 32;
    localparam int REG_W  = 18;
    localparam int CNT_W  = 16;
    localparam int TY_MSB = WORD_W - 1;
    localparam int TY_LSB = WORD_W - 4;

    localparam logic [3:0] TY_REG_OLD = 4'h0;
    localparam logic [3:0] TY_REG_NEW = 4'h4;
    localparam logic [3:0] TY_OP_NEW  = 4'h7;
    localparam logic [3:0] TY_NOP     = 4'h8;
    localparam logic [3:0] TY_OP_OLD  = 4'hC;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_PAYLOAD = 2'd1,
        ACT_DISCARD = 2'd2
    } act_e;

    typedef enum logic {
        TGT_REG = 1'b0,
        TGT_OP  = 1'b1
    } tgt_e;

    typedef struct packed {
        act_e             act;
        tgt_e             kind;
        logic [REG_W-1:0] target;
        logic [CNT_W-1:0] count;
        logic             par_err;
        logic             type_err;
    } hdr_info_t;

    // Expected guard bit: nibble-fold then look up in a 16-entry odd-fill table.
    function automatic logic odd_fill(input logic [WORD_W-1:0] v);
        logic [3:0]  n;
        logic [15:0] tbl;
        tbl = 16'h9669;
        n   = 4'h0;
        for (int i = 0; i < WORD_W / 4; i++) begin
            n = n ^ v[i*4 +: 4];
        end
        return tbl[n];
    endfunction

endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_info_t         info
);

    logic [6:0]  c4;
    logic [17:0] r4;
    logic [14:0] c7;
    logic [6:0]  o7;
    logic        bad4;
    logic        bad7;

    always_comb begin
        c4   = word[6:0];
        r4   = word[25:8];
        c7   = word[14:0];
        o7   = word[22:16];
        bad4 = (word[7]  != odd_fill(WORD_W'(c4))) || (word[27] != odd_fill(WORD_W'(r4)));
        bad7 = (word[15] != odd_fill(WORD_W'(c7))) || (word[23] != odd_fill(WORD_W'(o7)));
    end

    always_comb begin
        info          = '0;
        info.act      = ACT_NONE;
        info.kind     = TGT_REG;
        unique case (word[TY_MSB:TY_LSB])
            TY_REG_OLD: begin
                info.act    = ACT_PAYLOAD;
                info.kind   = TGT_REG;
                info.target = REG_W'(word[14:0]);
                info.count  = CNT_W'(word[27:16]) + CNT_W'(1);
            end
            TY_OP_OLD: begin
                info.act    = ACT_PAYLOAD;
                info.kind   = TGT_OP;
                info.target = REG_W'(word[15:8]);
                info.count  = CNT_W'(word[27:16]) + CNT_W'(1);
            end
            TY_REG_NEW: begin
                info.kind    = TGT_REG;
                info.target  = r4;
                info.count   = CNT_W'(c4);
                info.par_err = bad4;
                if (c4 != '0) begin
                    info.act = bad4 ? ACT_DISCARD : ACT_PAYLOAD;
                end
            end
            TY_OP_NEW: begin
                info.kind    = TGT_OP;
                info.target  = REG_W'(o7);
                info.count   = CNT_W'(c7);
                info.par_err = bad7;
                if (c7 != '0) begin
                    info.act = bad7 ? ACT_DISCARD : ACT_PAYLOAD;
                end
            end
            TY_NOP: begin
                info.act = ACT_NONE;
            end
            default: begin
                info.type_err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cmdp_payload_seq.sv
module cmdp_payload_seq
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  hdr_info_t         hdr,
    output logic              at_header,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_kind,
    output logic [REG_W-1:0]  out_target,
    output logic              out_last
);

    typedef enum logic [1:0] {S_HDR, S_PASS, S_DROP} state_e;

    state_e           state;
    logic [CNT_W-1:0] remain;
    logic [REG_W-1:0] target;
    tgt_e             kind;
    logic             take_hdr;
    logic             fire;
    logic             drop;
    logic             final_word;

    always_comb begin
        at_header  = (state == S_HDR);
        final_word = (remain == CNT_W'(1));
        in_ready   = (state == S_PASS) ? out_ready : 1'b1;
        out_valid  = (state == S_PASS) && in_valid;
        out_data   = in_data;
        out_kind   = kind;
        out_target = target;
        out_last   = (state == S_PASS) && final_word;
        take_hdr   = at_header && in_valid;
        fire       = out_valid && out_ready;
        drop       = (state == S_DROP) && in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_HDR;
            remain <= '0;
            target <= '0;
            kind   <= TGT_REG;
        end else begin
            unique case (state)
                S_HDR: begin
                    if (take_hdr) begin
                        remain <= hdr.count;
                        target <= hdr.target;
                        kind   <= hdr.kind;
                        if (hdr.act == ACT_PAYLOAD) begin
                            state <= S_PASS;
                        end else if (hdr.act == ACT_DISCARD) begin
                            state <= S_DROP;
                        end
                    end
                end
                S_PASS: begin
                    if (fire) begin
                        remain <= remain - CNT_W'(1);
                        if (kind == TGT_REG) begin
                            target <= target + REG_W'(1);
                        end
                        if (final_word) begin
                            state <= S_HDR;
                        end
                    end
                end
                S_DROP: begin
                    if (drop) begin
                        remain <= remain - CNT_W'(1);
                        if (final_word) begin
                            state <= S_HDR;
                        end
                    end
                end
                default: state <= S_HDR;
            endcase
        end
    end

    AST_LAST_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (fire && out_last) |=> at_header); // R10

    AST_REG_STEP: assert property (@(posedge clk) disable iff (rst)
        (fire && !out_last && kind == TGT_REG) |=> (out_target == $past(out_target) + REG_W'(1))); // R2

    AST_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fire && !out_last && kind == TGT_OP) |=> $stable(out_target)); // R4

    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (state == S_PASS)); // R11

endmodule

// File: rtl/cmdp_err_flags.sv
module cmdp_err_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_par,
    input  logic set_type,
    output logic err_parity,
    output logic err_type
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_parity <= 1'b0;
            err_type   <= 1'b0;
        end else begin
            if (set_par) begin
                err_parity <= 1'b1;
            end
            if (set_type) begin
                err_type <= 1'b1;
            end
        end
    end

    AST_PAR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_parity |=> err_parity); // R12

    AST_TYPE_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_type |=> err_type); // R12

endmodule

// File: rtl/cmd_hdr_parser.sv
module cmd_hdr_parser
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_kind,
    output logic [REG_W-1:0]  out_target,
    output logic              out_last,
    output logic              err_parity,
    output logic              err_type
);

    hdr_info_t info;
    logic      at_header;
    logic      hdr_take;

    cmdp_hdr_decode i_dec (
        .word (in_data),
        .info (info)
    );

    cmdp_payload_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .hdr        (info),
        .at_header  (at_header),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_kind   (out_kind),
        .out_target (out_target),
        .out_last   (out_last)
    );

    assign hdr_take = at_header && in_valid;

    cmdp_err_flags i_err (
        .clk        (clk),
        .rst        (rst),
        .set_par    (hdr_take && info.par_err),
        .set_type   (hdr_take && info.type_err),
        .err_parity (err_parity),
        .err_type   (err_type)
    );

    AST_BAD_HDR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (hdr_take && info.par_err) |=> err_parity); // R6

    AST_BAD_HDR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (hdr_take && (info.par_err || info.type_err)) |=> !out_valid); // R8

    AST_HDR_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        at_header |-> !out_valid); // R7

endmodule

// File: tb/test_cmd_hdr_parser.sv
module test_cmd_hdr_parser;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_kind;
    logic [17:0] out_target;
    logic        out_last;
    logic        err_parity;
    logic        err_type;

    int checks = 0;
    int errors = 0;
    int seq    = 0;
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic [31:0] d;
        logic        kind;
        logic [17:0] tgt;
        logic        last;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    cmd_hdr_parser i_cmd_hdr_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_kind(out_kind),
        .out_target(out_target), .out_last(out_last), .err_parity(err_parity), .err_type(err_type)
    );

    function automatic logic gbit(input logic [31:0] v);
        int ones = 0;
        for (int i = 0; i < 32; i++) ones += int'(v[i]);
        return (ones % 2) == 0;
    endfunction

    function automatic logic [31:0] mk4(input logic [17:0] r, input logic [6:0] c);
        return {4'h4, gbit(32'(r)), 1'b0, r, gbit(32'(c)), c};
    endfunction
    function automatic logic [31:0] mk7(input logic [6:0] op, input logic [14:0] c);
        return {4'h7, 4'h0, gbit(32'(op)), op, gbit(32'(c)), c};
    endfunction
    function automatic logic [31:0] mk0(input logic [14:0] r, input int cnt);
        return {4'h0, 12'(cnt - 1), 1'b0, r};
    endfunction
    function automatic logic [31:0] mk3(input logic [7:0] op, input int cnt);
        return {4'hC, 12'(cnt - 1), op, 8'h00};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic pkt(input logic [31:0] h, input logic kind, input logic [17:0] tgt,
                       input int cnt, input string req);
        for (int i = 0; i < cnt; i++) begin
            exp_t e;
            e.d    = 32'hA500_0000 + 32'(seq + i);
            e.kind = kind;
            e.tgt  = (kind == 1'b0) ? 18'(tgt + 18'(i)) : tgt;
            e.last = (i == cnt - 1);
            e.req  = req;
            sb.push_back(e);
        end
        send(h);
        for (int i = 0; i < cnt; i++) send(32'hA500_0000 + 32'(seq + i));
        seq += cnt;
    endtask

    task automatic drain();
        int n = 0;
        while (sb.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R10 scoreboard drained", 32'(sb.size()), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // output-ready pattern
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && out_valid) begin
                chk(out_data == in_data && in_ready == out_ready, "R11 passthrough",
                    out_data, in_data);
                if (out_ready) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R7 unexpected output word", out_data, 32'h0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(out_data == e.d, e.req, out_data, e.d);
                        chk(out_kind == e.kind, e.req, 32'(out_kind), 32'(e.kind));
                        chk(out_target == e.tgt, e.req, 32'(out_target), 32'(e.tgt));
                        chk(out_last == e.last, "R10 last flag", 32'(out_last), 32'(e.last));
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", checks);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        chk(err_parity == 1'b0 && err_type == 1'b0, "R1 flags", {err_parity, err_type}, 32'd0);

        // R2 basic and wrap
        pkt(mk4(18'h2ABCD, 7'd3), 1'b0, 18'h2ABCD, 3, "R2 type4 run");
        pkt(mk4(18'h3FFFE, 7'd3), 1'b0, 18'h3FFFE, 3, "R2 index wrap");
        // R3
        pkt(mk0(15'h7FFF, 2), 1'b0, 18'h07FFF, 2, "R3 type0 run");
        pkt(mk0(15'h0010, 1), 1'b0, 18'h00010, 1, "R3 type0 single");
        // R4
        pkt(mk3(8'h5A, 3), 1'b1, 18'h0005A, 3, "R4 type3 run");
        drain();

        stall_en = 1'b1;
        // R5 with stalls (R11)
        pkt(mk7(7'h71, 15'd4), 1'b1, 18'h00071, 4, "R5 type7 run");
        pkt(mk4(18'h00100, 7'd5), 1'b0, 18'h00100, 5, "R11 R2 stalled run");
        // R7
        send(32'h8000_0000);
        pkt(mk4(18'h00200, 7'd1), 1'b0, 18'h00200, 1, "R7 after no-op");
        // R9
        send(mk4(18'h00300, 7'd0));
        send(mk7(7'h12, 15'd0));
        pkt(mk7(7'h13, 15'd1), 1'b1, 18'h00013, 1, "R9 after empty headers");
        // R2 max count
        pkt(mk4(18'h01000, 7'd127), 1'b0, 18'h01000, 127, "R2 max count 127");
        drain();
        chk(err_parity == 1'b0, "R6 no false parity", 32'(err_parity), 32'd0);
        chk(err_type == 1'b0, "R8 no false type", 32'(err_type), 32'd0);

        // R8 unknown type
        send(32'h1234_5678);
        pkt(mk4(18'h00400, 7'd2), 1'b0, 18'h00400, 2, "R8 after unknown");
        drain();
        chk(err_type == 1'b1, "R8 err_type set", 32'(err_type), 32'd1);
        chk(err_parity == 1'b0, "R8 parity untouched", 32'(err_parity), 32'd0);

        // R6 bad index parity, payload discarded
        do_reset();
        #2;
        chk(err_type == 1'b0, "R12 reset clears err_type", 32'(err_type), 32'd0);
        h = mk4(18'h00500, 7'd2) ^ 32'h0800_0000;
        send(h);
        send(32'hDEAD_0001);
        send(32'hDEAD_0002);
        pkt(mk7(7'h22, 15'd2), 1'b1, 18'h00022, 2, "R6 resume after bad index parity");
        drain();
        chk(err_parity == 1'b1, "R6 err_parity set", 32'(err_parity), 32'd1);
        // R6 bad count parity on type7
        h = mk7(7'h33, 15'd1) ^ 32'h0000_8000;
        send(h);
        send(32'hDEAD_0003);
        pkt(mk3(8'hEE, 2), 1'b1, 18'h000EE, 2, "R6 resume after bad count parity");
        // R12 sticky across good traffic
        pkt(mk0(15'h0001, 3), 1'b0, 18'h00001, 3, "R12 traffic after error");
        drain();
        chk(err_parity == 1'b1, "R12 err_parity sticky", 32'(err_parity), 32'd1);
        do_reset();
        #2;
        chk(err_parity == 1'b0, "R12 reset clears err_parity", 32'(err_parity), 32'd0);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after second reset",
            {in_ready, out_valid}, 32'h2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule